// File: doc/BRIEF.md
# Link Transmit Arbiter with Periodic Control Slot

This block decides which of three packet sources drives a 32-bit link transmit path: a source of freshly framed packets, a source that replays packets already sent, and a source of link-control packets. Each source raises a request, receives a one-hot grant and presents its data words. It marks its final word with an end-of-packet strobe. A grant stays with its owner for the whole packet. The next grant is loaded in the cycle after the owner's end-of-packet word, so packets can follow each other without an idle cycle.

A free-running interval counter makes sure link-control traffic gets its turn. The counter restarts at zero each time a control grant is issued. Once it comes within a guard window of the interval length, no replay or new packet may start, so the control slot begins on time. If the control packet has still not been granted, the counter holds at its top value and data traffic stays stalled. Outside the window a pending control request still wins, replay traffic beats new traffic, and with no request at all the link output is idle.

Top module: `link_tx_arbiter`

## Requirements
- R1: During and right after reset, all grants are low, `tx_valid` is 0 and `tx_data` is 0. The interval counter starts at zero.
- R2: `gnt` is always one-hot or zero. Bit 0 is the new-packet source, bit 1 is the replay source and bit 2 is the control source.
- R3: While a grant is held, it does not change unless the owning source asserts its end-of-packet strobe in that cycle.
- R4: When the arbiter is free (no grant held, or the owner signals end-of-packet) and `req_ctl` is high, `gnt[2]` is set in the next cycle.
- R5: When the arbiter is free, outside the guard window and with no control request, a replay request wins over a new-packet request in the next cycle.
- R6: When the arbiter is free inside the guard window, neither `gnt[0]` nor `gnt[1]` is set in the next cycle. The guard window is an interval count of at least `INTERVAL_CYC - GUARD_CYC`.
- R7: The interval count is 0 in the cycle after a control grant is loaded. It then rises by one per cycle and saturates at `INTERVAL_CYC - 1`.
- R8: `tx_data` equals the data input of the granted source, and `tx_valid` is high exactly when some grant is held. With no grant, `tx_data` is 0.
- R9: After an end-of-packet from the owner, the next grant is chosen in the same decision, with no idle cycle between packets when a request is pending.
- R10: An end-of-packet strobe from a source that does not hold the grant has no effect on the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_new | input | 1 | New-packet source requests the link |
| req_rty | input | 1 | Replay source requests the link |
| req_ctl | input | 1 | Link-control source requests the link |
| eop_new | input | 1 | New-packet source is on its last word |
| eop_rty | input | 1 | Replay source is on its last word |
| eop_ctl | input | 1 | Control source is on its last word |
| data_new | input | 32 | New-packet data word |
| data_rty | input | 32 | Replay data word |
| data_ctl | input | 32 | Control data word |
| gnt | output | 3 | One-hot grant: bit 0 new, bit 1 replay, bit 2 control |
| tx_valid | output | 1 | Link output carries a granted word |
| tx_data | output | 32 | Link output word |

## Verification
Random request mixes run in two phases. In the first, control requests are frequent and the counter rarely nears the guard window, so the replay-over-new ordering and back-to-back handoff decide every pick. In the second, control requests are scarce, so the counter enters the window and saturates. That phase separates a correct window stall, and the exact cycle count after each control grant, from a design that lets data start late or restarts the count at the wrong time. End-of-packet strobes are raised randomly on sources that do not hold the grant, which separates a design that honours only the owner's strobe from one that releases on any strobe. A directed reset sequence and an idle stretch with no requests check the quiet output.

// File: rtl/ltx_arb_pkg.sv
package ltx_arb_pkg;

  localparam int unsigned NSRC = 3;
  localparam int unsigned SRC_NEW = 0;
  localparam int unsigned SRC_RTY = 1;
  localparam int unsigned SRC_CTL = 2;

  // Next grant from requests when the arbiter is free.
  function automatic logic [NSRC-1:0] pick_grant(input logic [NSRC-1:0] req,
                                                 input logic win);
    logic [NSRC-1:0] g;
    g = '0;
    if (req[SRC_CTL])               g[SRC_CTL] = 1'b1;
    else if (!win && req[SRC_RTY])  g[SRC_RTY] = 1'b1;
    else if (!win && req[SRC_NEW])  g[SRC_NEW] = 1'b1;
    return g;
  endfunction

  // Guard window test on the interval count.
  function automatic logic in_window(input int unsigned cnt,
                                     input int unsigned ivl,
                                     input int unsigned guard);
    return cnt >= (ivl - guard);
  endfunction

endpackage

// File: rtl/ltx_interval_cnt.sv
module ltx_interval_cnt
  import ltx_arb_pkg::*;
#(
  parameter int unsigned INTERVAL_CYC = 8500,
  parameter int unsigned GUARD_CYC    = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_start,
  output logic win
);
  localparam int unsigned CW  = $clog2(INTERVAL_CYC);
  localparam logic [CW-1:0] TOP = CW'(INTERVAL_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          at_top;

  assign at_top = (cnt_q == TOP);

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt_q <= '0;
    else if (ctl_start) cnt_q <= '0;
    else if (!at_top)   cnt_q <= cnt_q + 1'b1;
  end

  assign win = in_window(int'(cnt_q), INTERVAL_CYC, GUARD_CYC);

  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_start |=> (cnt_q == '0)); // R7
  AST_CNT_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TOP); // R7
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_start && !at_top) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R7

endmodule

// File: rtl/ltx_grant_ctrl.sv
module ltx_grant_ctrl
  import ltx_arb_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req,
  input  logic [NSRC-1:0] eop,
  input  logic            win,
  output logic [NSRC-1:0] gnt_q,
  output logic            ctl_start
);
  logic            owner_eop;
  logic            free;
  logic [NSRC-1:0] pick;

  assign owner_eop = |(gnt_q & eop);
  assign free      = (gnt_q == '0) || owner_eop;
  assign pick      = pick_grant(req, win);
  assign ctl_start = free && pick[SRC_CTL];

  always_ff @(posedge clk) begin
    if (!rst_n)    gnt_q <= '0;
    else if (free) gnt_q <= pick;
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_q)); // R2
  AST_GNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt_q != '0) && !owner_eop) |=> $stable(gnt_q)); // R3
  AST_CTL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (free && req[SRC_CTL]) |=> gnt_q[SRC_CTL]); // R4
  AST_RTY_OVER_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    (free && !win && !req[SRC_CTL] && req[SRC_RTY]) |=> gnt_q[SRC_RTY]); // R5
  AST_WIN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (free && win) |=> !(gnt_q[SRC_NEW] || gnt_q[SRC_RTY])); // R6

endmodule

// File: rtl/ltx_data_mux.sv
module ltx_data_mux
  import ltx_arb_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic [NSRC-1:0]        gnt,
  input  logic [NSRC-1:0][DW-1:0] din,
  output logic [DW-1:0]          tx_data,
  output logic                   tx_valid
);
  always_comb begin
    tx_data = '0;
    for (int i = 0; i < NSRC; i++) begin
      tx_data = tx_data | (din[i] & {DW{gnt[i]}});
    end
  end

  assign tx_valid = |gnt;

  always_comb begin
    if ($onehot(gnt)) begin
      AST_MUX_PASS: assert (tx_valid && (tx_data == din[$clog2(gnt)])); // R8
    end
  end

endmodule

// File: rtl/link_tx_arbiter.sv
module link_tx_arbiter
  import ltx_arb_pkg::*;
#(
  parameter int unsigned DW           = 32,
  parameter int unsigned INTERVAL_CYC = 8500,
  parameter int unsigned GUARD_CYC    = 250
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_new,
  input  logic          req_rty,
  input  logic          req_ctl,
  input  logic          eop_new,
  input  logic          eop_rty,
  input  logic          eop_ctl,
  input  logic [DW-1:0] data_new,
  input  logic [DW-1:0] data_rty,
  input  logic [DW-1:0] data_ctl,
  output logic [2:0]    gnt,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data
);
  logic [NSRC-1:0]         req_v;
  logic [NSRC-1:0]         eop_v;
  logic [NSRC-1:0][DW-1:0] din_v;
  logic                    win;
  logic                    ctl_start;
  logic [NSRC-1:0]         gnt_q;

  assign req_v = {req_ctl, req_rty, req_new};
  assign eop_v = {eop_ctl, eop_rty, eop_new};
  assign din_v = {data_ctl, data_rty, data_new};

  ltx_interval_cnt #(
    .INTERVAL_CYC(INTERVAL_CYC),
    .GUARD_CYC   (GUARD_CYC)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_start(ctl_start),
    .win      (win)
  );

  ltx_grant_ctrl u_gnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req_v),
    .eop      (eop_v),
    .win      (win),
    .gnt_q    (gnt_q),
    .ctl_start(ctl_start)
  );

  ltx_data_mux #(.DW(DW)) u_mux (
    .gnt     (gnt_q),
    .din     (din_v),
    .tx_data (tx_data),
    .tx_valid(tx_valid)
  );

  assign gnt = gnt_q;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == '0) |-> (!tx_valid && tx_data == '0)); // R8

endmodule

// File: tb/tb_link_tx_arbiter.sv
module tb_link_tx_arbiter;
  localparam int IV = 40;
  localparam int GD = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_new = 0, req_rty = 0, req_ctl = 0;
  logic eop_new = 0, eop_rty = 0, eop_ctl = 0;
  logic [31:0] data_new = 0, data_rty = 0, data_ctl = 0;
  logic [2:0]  gnt;
  logic        tx_valid;
  logic [31:0] tx_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [2:0] m_gnt;
  int         m_cnt;
  string      cause;

  always #2 clk = ~clk;

  link_tx_arbiter #(.DW(32), .INTERVAL_CYC(IV), .GUARD_CYC(GD)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_new(req_new), .req_rty(req_rty), .req_ctl(req_ctl),
    .eop_new(eop_new), .eop_rty(eop_rty), .eop_ctl(eop_ctl),
    .data_new(data_new), .data_rty(data_rty), .data_ctl(data_ctl),
    .gnt(gnt), .tx_valid(tx_valid), .tx_data(tx_data)
  );

  function automatic logic [31:0] exp_data(input logic [2:0] g);
    case (g)
      3'b001:  return data_new;
      3'b010:  return data_rty;
      3'b100:  return data_ctl;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_outputs();
    check({"gnt ", cause}, {29'h0, gnt}, {29'h0, m_gnt});
    check("R2 onehot", {31'h0, $onehot0(gnt)}, 32'h1);
    check("R8 valid", {31'h0, tx_valid}, {31'h0, (m_gnt != 0)});
    check("R8 data", tx_data, exp_data(m_gnt));
  endtask

  // Reference model step from the inputs that the next edge samples.
  task automatic model_step();
    logic own, win, freed;
    logic [2:0] ng;
    own = (m_gnt[0] & eop_new) | (m_gnt[1] & eop_rty) | (m_gnt[2] & eop_ctl);
    freed = (m_gnt == 0) || own;
    win = (m_cnt >= IV - GD);
    ng = m_gnt;
    if (!freed) begin
      cause = ((eop_new | eop_rty | eop_ctl) != 0) ? "R3 R10 held" : "R3 held";
    end else if (req_ctl) begin
      ng = 3'b100; cause = "R4 ctl";
    end else if (win) begin
      ng = 3'b000; cause = "R6 R7 window";
    end else if (req_rty) begin
      ng = 3'b010; cause = req_new ? "R5 rty over new" : "R9 rty";
    end else if (req_new) begin
      ng = 3'b001; cause = "R9 new";
    end else begin
      ng = 3'b000; cause = "R8 idle";
    end
    if (freed && ng[2]) m_cnt = 0;
    else if (m_cnt < IV - 1) m_cnt = m_cnt + 1;
    m_gnt = ng;
  endtask

  task automatic drive_rand(input int ctl_mod);
    req_ctl = ($urandom % ctl_mod) == 0;
    req_rty = ($urandom % 2) == 0;
    req_new = ($urandom % 4) != 0;
    eop_new = ($urandom % 3) == 0;
    eop_rty = ($urandom % 3) == 0;
    eop_ctl = ($urandom % 3) == 0;
    data_new = $urandom; data_rty = $urandom; data_ctl = $urandom;
  endtask

  task automatic run_cycles(input int n, input int ctl_mod, input bit quiet);
    for (int i = 0; i < n; i++) begin
      check_outputs();
      if (quiet) begin
        {req_ctl, req_rty, req_new} = 3'b000;
        {eop_ctl, eop_rty, eop_new} = 3'b111;
        data_new = $urandom; data_rty = $urandom; data_ctl = $urandom;
      end else begin
        drive_rand(ctl_mod);
      end
      model_step();
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0017));
    m_gnt = 3'b000; m_cnt = 0; cause = "R1 reset";
    data_new = 32'hA5A5_0001; data_rty = 32'hA5A5_0002; data_ctl = 32'hA5A5_0003;
    req_new = 1; req_rty = 1; req_ctl = 1;
    repeat (3) @(negedge clk);
    check("R1 gnt", {29'h0, gnt}, 32'h0);
    check("R1 valid", {31'h0, tx_valid}, 32'h0);
    check("R1 data", tx_data, 32'h0);
    rst_n = 1'b1;
    // First decision after reset with all requests: control wins (R4).
    cause = "R1 reset";
    model_step();
    @(negedge clk);
    run_cycles(1500, 4, 0);
    run_cycles(20, 4, 1);
    run_cycles(2500, 64, 0);
    run_cycles(20, 4, 1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule